// File: doc/BRIEF.md
# Tick-Driven Watchdog Timeout Stage

This block is the final stage of a watchdog timer. An upstream divider chain supplies a periodic one-cycle tick. The block counts those ticks in a three-bit stage. When the stage rolls over from its top value back to zero, the block raises a one-cycle reset request. That request goes to the system reset sequencer, which restarts the processor through its normal reset vector.

Software keeps the system alive by writing to a fixed service address. The write clears only the three-bit stage and never touches the upstream divider. The divider keeps running, so the next tick can arrive at any point within its period. As a result, the time from a service write to a timeout is at least seven and at most eight tick periods.

A configuration enable gates the whole function. While the enable is low, the stage is held at zero and no request is raised, so each enable starts a full count.

Top module: `wdg_tick_watchdog`

## Requirements
- R1: While the synchronous reset `rst` is high, `rst_req` is 0, and the stage returns to 0. After reset is released, exactly eight enabled ticks are needed before the next request.
- R2: With `wdg_en` high, each cycle with `tick` high advances the stage by one. The eighth tick since the stage was last at zero makes `rst_req` high in the cycle right after the clock edge that samples that tick.
- R3: After a rollover the stage keeps counting from zero, so every further eight ticks produce another request. This holds even when ticks arrive on back-to-back cycles.
- R4: A write (`bus_we` = 1) to address 0x0FF0 with `bus_data` bit 0 equal to 0 sets the stage to 0. Eight more ticks are then needed for a request.
- R5: A write to 0x0FF0 with `bus_data` bit 0 equal to 1 leaves the stage unchanged.
- R6: A write to any other address leaves the stage unchanged. So does the service address and data presented with `bus_we` at 0.
- R7: When a clearing write and a tick occur in the same cycle, the clear takes effect and the stage becomes 0.
- R8: While `wdg_en` is 0, the stage is held at 0 and `rst_req` stays 0. After `wdg_en` returns to 1, eight ticks are needed for a request.
- R9: Only bit 0 of `bus_data` decides a service write. A write of 0xFE to 0x0FF0 clears the stage.
- R10: `rst_req` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse from the upstream periodic divider |
| wdg_en | input | 1 | Watchdog enable from the configuration register |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 16 | Bus write address |
| bus_data | input | 8 | Bus write data |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with its default parameters: a three-bit stage (eight ticks per timeout) and the service address 0x0FF0. A short stage means each rollover takes only a few dozen cycles. That makes it practical to repeat timeouts, mid-count service writes, a clear colliding with a tick, and enable toggling many times in one run. Ticks are applied both spaced out and on back-to-back cycles, so request timing is checked against tick arrival and not against a fixed cycle count.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] SVC_ADDR_DEF = 16'h0FF0;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wdg_wr_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_ZERO = 2'd1,
        ACT_STEP = 2'd2
    } stage_act_e;

    // Clear has priority over a tick; a disabled watchdog is forced to zero.
    function automatic stage_act_e pick_action(input logic en, input logic clr, input logic tk);
        if (!en || clr) return ACT_ZERO;
        if (tk)         return ACT_STEP;
        return ACT_HOLD;
    endfunction

    function automatic logic is_service(input wdg_wr_t wr, input logic [ADDR_W-1:0] svc);
        return wr.we && (wr.addr == svc) && !wr.data[0];
    endfunction

endpackage

// File: rtl/wdg_svc_decode.sv
module wdg_svc_decode
    import wdg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SVC_ADDR = SVC_ADDR_DEF
) (
    input  wdg_wr_t wr,
    output logic    clr
);

    always_comb clr = is_service(wr, SVC_ADDR);

endmodule

// File: rtl/wdg_div_stage.sv
module wdg_div_stage
    import wdg_pkg::*;
#(
    parameter int STAGE_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               clr,
    input  logic               tick,
    output logic [STAGE_W-1:0] cnt,
    output logic               wrap
);

    localparam logic [STAGE_W-1:0] TOP_VAL = '1;
    localparam logic [STAGE_W-1:0] ONE_VAL = {{(STAGE_W-1){1'b0}}, 1'b1};

    stage_act_e act;

    always_comb begin
        act  = pick_action(en, clr, tick);
        wrap = (act == ACT_STEP) && (cnt == TOP_VAL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case (act)
                ACT_ZERO: cnt <= '0;
                ACT_STEP: cnt <= cnt + ONE_VAL;
                default:  cnt <= cnt;
            endcase
        end
    end

    AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (en && tick && !clr) |=> (cnt == $past(cnt) + ONE_VAL)); // R2
    AST_CLEAR_BEATS_TICK: assert property (@(posedge clk) disable iff (rst)
        (en && clr) |=> (cnt == '0)); // R7
    AST_HELD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0)); // R8
    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (en && !tick && !clr) |=> $stable(cnt)); // R5

endmodule

// File: rtl/wdg_req_pulse.sv
module wdg_req_pulse (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    output logic req
);

    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= wrap;
    end

    AST_ONE_CYCLE_REQ: assert property (@(posedge clk) disable iff (rst)
        req |=> !req); // R10

endmodule

// File: rtl/wdg_tick_watchdog.sv
module wdg_tick_watchdog
    import wdg_pkg::*;
#(
    parameter int                STAGE_W  = 3,
    parameter logic [ADDR_W-1:0] SVC_ADDR = SVC_ADDR_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wdg_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              rst_req
);

    localparam logic [STAGE_W-1:0] TOP_VAL = '1;

    wdg_wr_t            wr;
    logic               svc_clr;
    logic [STAGE_W-1:0] stage_cnt;
    logic               stage_wrap;

    always_comb wr = '{we: bus_we, addr: bus_addr, data: bus_data};

    wdg_svc_decode #(.SVC_ADDR(SVC_ADDR)) u_decode (
        .wr  (wr),
        .clr (svc_clr)
    );

    wdg_div_stage #(.STAGE_W(STAGE_W)) u_stage (
        .clk  (clk),
        .rst  (rst),
        .en   (wdg_en),
        .clr  (svc_clr),
        .tick (tick),
        .cnt  (stage_cnt),
        .wrap (stage_wrap)
    );

    wdg_req_pulse u_pulse (
        .clk  (clk),
        .rst  (rst),
        .wrap (stage_wrap),
        .req  (rst_req)
    );

    AST_REQ_FROM_ROLLOVER: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> ($past(stage_cnt) == TOP_VAL && stage_cnt == '0)); // R2
    AST_SERVICE_ZEROES: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == SVC_ADDR && !bus_data[0]) |=> (stage_cnt == '0)); // R4
    AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !wdg_en |=> !rst_req); // R8

endmodule

// File: tb/wdg_tick_watchdog_test.sv
`timescale 1ns/1ps
module wdg_tick_watchdog_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wdg_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_data = 8'h00;
    logic        rst_req;

    always #4 clk = ~clk;

    wdg_tick_watchdog uut (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .wdg_en   (wdg_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_data (bus_data),
        .rst_req  (rst_req)
    );

    typedef struct {
        int    at;
        string tag;
    } exp_t;

    exp_t  sb[$];
    int    cyc = 0;
    int    vectors = 0;
    int    misses = 0;
    int    model = 0;
    string cur_tag = "R1";
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: every cycle, a request is expected exactly when the scoreboard says so.
    always @(negedge clk) begin
        if (!done) begin
            logic  want;
            string tag;
            want = 1'b0;
            tag  = cur_tag;
            if (sb.size() > 0 && sb[0].at == cyc) begin
                want = 1'b1;
                tag  = sb[0].tag;
                void'(sb.pop_front());
            end
            if (rst) tag = "R1";
            vectors++;
            if (rst_req !== want) begin
                misses++;
                $display("FAIL %s cycle %0d: rst_req=%b expected %b", tag, cyc, rst_req, want);
            end
        end
    end

    // Driver: applies one cycle of stimulus and updates the reference count.
    task automatic step(input logic tk, input logic we, input logic [15:0] a, input logic [7:0] d);
        tick = tk; bus_we = we; bus_addr = a; bus_data = d;
        if (rst) begin
            model = 0;
        end else if (!wdg_en || (we && a == 16'h0FF0 && !d[0])) begin
            model = 0;
        end else if (tk) begin
            if (model == 7) begin
                sb.push_back('{at: cyc + 1, tag: cur_tag});
                model = 0;
            end else begin
                model++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0; bus_we = 1'b0;
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0, 16'h0000, 8'h00);
            for (int g = 0; g < gap; g++) step(1'b0, 1'b0, 16'h0000, 8'h00);
        end
    endtask

    initial begin
        @(negedge clk);
        cur_tag = "R1";
        ticks(3, 0);
        rst = 1'b0;
        wdg_en = 1'b1;
        // R2: spaced ticks, eight needed from reset
        cur_tag = "R2";
        ticks(8, 2);
        // R3: continuous ticks, repeated rollovers
        cur_tag = "R3";
        ticks(16, 0);
        ticks(5, 1);
        // R4: service write mid-count
        cur_tag = "R4";
        step(1'b0, 1'b1, 16'h0FF0, 8'h00);
        ticks(8, 1);
        // R9: upper data bits do not matter
        cur_tag = "R9";
        ticks(6, 0);
        step(1'b0, 1'b1, 16'h0FF0, 8'hFE);
        ticks(8, 0);
        // R5: bit 0 set does not clear
        cur_tag = "R5";
        ticks(5, 0);
        step(1'b0, 1'b1, 16'h0FF0, 8'h01);
        step(1'b0, 1'b1, 16'h0FF0, 8'hFF);
        ticks(3, 1);
        // R6: other address, or no strobe
        cur_tag = "R6";
        ticks(5, 0);
        step(1'b0, 1'b1, 16'h0FF1, 8'h00);
        step(1'b0, 1'b1, 16'h1FF0, 8'h00);
        step(1'b0, 1'b0, 16'h0FF0, 8'h00);
        ticks(3, 0);
        // R7: clear and tick together
        cur_tag = "R7";
        ticks(7, 0);
        step(1'b1, 1'b1, 16'h0FF0, 8'h00);
        ticks(8, 1);
        // R8: disable holds at zero, re-enable starts fresh
        cur_tag = "R8";
        ticks(7, 0);
        wdg_en = 1'b0;
        ticks(12, 0);
        wdg_en = 1'b1;
        ticks(8, 2);
        // R1: reset mid-count
        cur_tag = "R1";
        ticks(6, 0);
        rst = 1'b1;
        ticks(2, 0);
        rst = 1'b0;
        ticks(8, 1);
        // R10 is checked on every cycle above: no request outside the expected cycle
        cur_tag = "R10";
        ticks(0, 0);
        step(1'b0, 1'b0, 16'h0000, 8'h00);
        step(1'b0, 1'b0, 16'h0000, 8'h00);
        if (sb.size() != 0) begin
            misses++;
            $display("FAIL R2 pending requests: %0d expected 0", sb.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            misses++;
            $display("FAIL watchdog: run incomplete, expected end of stimulus");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule